// File: doc/BRIEF.md
# Address-Masked GPIO Port with Pin Interrupts

This block is an eight-pin general purpose I/O port on a simple single-cycle register bus. Software reaches the pin data through a 1 KB window. The word-address bits inside that window form a per-bit access mask, so a read returns only the selected bits and a write changes only the selected bits. Software does not need a read-modify-write sequence to touch one pin.

Each pin has a direction bit. A pin configured as an input drives its output high and samples the external level through a synchronizer. A pin configured as an output drives its data bit.

An interrupt unit watches the input pins. Each pin can be set to detect a level or an edge, and each pin has a polarity bit. An edge-detecting pin can also be set to trigger on both edges. Raw status bits are sticky until software acknowledges them with a write-one-to-clear. The interrupt output is the OR of the raw status bits that the interrupt mask enables.

Fixed identification bytes sit at the top of the 4 KB space. A read of an unmapped offset returns zero and raises a one-cycle error flag.

Top module: `gpio_mask_irq`

## Requirements
- R1: After reset, the pin data, direction, sense, both-edge, polarity, mask and raw status registers all read 0, `pin_o` is all ones and `irq_o` is 0.
- R2: A read at byte offset below 0x400 returns the pin data ANDed with mask `addr_i[9:2]` in `rdata_o[7:0]`, with upper bits 0. All read data and `err_o` appear in the cycle after the request.
- R3: A write at byte offset below 0x400 changes only the data bits set both in mask `addr_i[9:2]` and in the direction register. Every other data bit of an output pin keeps its value.
- R4: `pin_o` equals (data AND direction) OR NOT direction, so a pin with direction bit 0 drives 1.
- R5: A data bit with direction bit 0 follows `pin_i` within three clock cycles. A bit with direction bit 1 ignores `pin_i`.
- R6: The direction (0x400), sense (0x404), both-edge (0x408), polarity (0x40C) and mask (0x410) registers store `wdata_i[7:0]` on write and read back with the upper 24 bits 0.
- R7: An input pin with sense bit 0 and both-edge bit 0 sets its raw status bit only on a change to the level equal to its polarity bit. Polarity 1 means rising and 0 means falling.
- R8: An input pin with sense bit 0 and both-edge bit 1 sets its raw status bit on every change.
- R9: An input pin with sense bit 1 sets its raw status bit in every cycle its level equals its polarity bit, so a clear does not remove it while that level persists.
- R10: Raw status reads at 0x414 and masked status (raw AND mask) reads at 0x418. Writing 1 to a bit at 0x41C clears that raw bit. Writes to 0x414 and 0x418 have no effect.
- R11: `irq_o` is 1 exactly when raw status AND mask is non-zero.
- R12: Reads at 0xFD0 to 0xFFC return one identification byte per word: 0x00, 0x00, 0x00, 0x00, 0x61, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R13: A read of any other offset returns 0 with `err_o` high for one cycle. This includes 0x41C, which is write-only. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| err_o | output | 1 | Unmapped-read flag, one cycle |
| pin_i | input | 8 | External pin levels |
| pin_o | output | 8 | Pin drive values |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench sweeps all 256 address masks for masked reads and masked writes against a mixed direction pattern. A design that ignored the direction register on writes, or that took the mask from the wrong address bits, would return wrong data on most masks.

The interrupt sequence covers the following cases:
- An edge of the wrong polarity, which a faulty polarity compare would latch.
- Both-edge capture.
- A level source that sets again straight after a clear, which a design without a level path would lose.
- Writes to the read-only status offsets, which must leave the status unchanged.

Unmapped reads, including the write-only clear offset, must return 0 with the error flag raised.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  // word offsets (byte offset >> 2)
  localparam logic [9:0] WOFS_DIR   = 10'h100;
  localparam logic [9:0] WOFS_SENSE = 10'h101;
  localparam logic [9:0] WOFS_BOTH  = 10'h102;
  localparam logic [9:0] WOFS_POL   = 10'h103;
  localparam logic [9:0] WOFS_MASK  = 10'h104;
  localparam logic [9:0] WOFS_RAW   = 10'h105;
  localparam logic [9:0] WOFS_MIS   = 10'h106;
  localparam logic [9:0] WOFS_CLR   = 10'h107;
  localparam logic [9:0] WOFS_ID0   = 10'h3F4;

  typedef struct packed {
    logic win;
    logic dir;
    logic sense;
    logic both;
    logic pol;
    logic msk;
    logic raw;
    logic mis;
    logic clr;
    logic id;
    logic unmapped;
  } dec_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd4:    id_byte = 8'h61;
      4'd5:    id_byte = 8'h10;
      4'd6:    id_byte = 8'h04;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/gpio_bus_dec.sv
module gpio_bus_dec
  import gpio_mask_pkg::*;
(
  input  logic [11:0] addr_i,
  output dec_t        dec_o
);
  logic [9:0] wofs;
  logic       unused_lsb;

  assign wofs       = addr_i[11:2];
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    dec_o       = '0;
    dec_o.win   = (wofs[9:8] == 2'b00);
    dec_o.dir   = (wofs == WOFS_DIR);
    dec_o.sense = (wofs == WOFS_SENSE);
    dec_o.both  = (wofs == WOFS_BOTH);
    dec_o.pol   = (wofs == WOFS_POL);
    dec_o.msk   = (wofs == WOFS_MASK);
    dec_o.raw   = (wofs == WOFS_RAW);
    dec_o.mis   = (wofs == WOFS_MIS);
    dec_o.clr   = (wofs == WOFS_CLR);
    dec_o.id    = (wofs >= WOFS_ID0);
    // clear offset is write-only, so it counts as unmapped for reads
    dec_o.unmapped = !(dec_o.win | dec_o.dir | dec_o.sense | dec_o.both |
                       dec_o.pol | dec_o.msk | dec_o.raw | dec_o.mis | dec_o.id);
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] in_en_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q, status_q;
  logic [W-1:0] chg_w, match_w, edge_set_w, lvl_set_w, set_w;

  assign chg_w      = (lvl_i ^ prev_q) & in_en_i;
  assign match_w    = ~(lvl_i ^ pol_i);
  assign edge_set_w = chg_w & ~sense_i & (both_i | match_w);
  assign lvl_set_w  = sense_i & match_w & in_en_i;
  assign set_w      = edge_set_w | lvl_set_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl_i;
      status_q <= (status_q & ~clr_i) | set_w;  // set wins over clear
    end
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & mask_i);

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((status_q & $past(clr_i & ~set_w)) == '0)); // R10
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_q) & ~status_q & ~$past(clr_i)) == '0)); // R10
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_i != '0)); // R11
endmodule

// File: rtl/gpio_mask_irq.sv
module gpio_mask_irq
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             err_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic             irq_o
);
  localparam int unsigned MSB = NPINS + 1;

  dec_t             dec;
  logic             wr, rd;
  logic [NPINS-1:0] amask, wd, pin_s;
  logic [NPINS-1:0] data_q, dir_q, sense_q, both_q, pol_q, mask_q;
  logic [NPINS-1:0] status, clr;
  logic [3:0]       id_idx;
  logic [31:0]      rdata_d, rdata_q;
  logic             err_q;
  logic             unused_wd;

  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;
  assign amask     = addr_i[MSB:2];
  assign wd        = wdata_i[NPINS-1:0];
  assign id_idx    = addr_i[5:2] - 4'd4;
  assign unused_wd = ^wdata_i[31:NPINS];

  gpio_bus_dec u_dec (.addr_i(addr_i), .dec_o(dec));

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
    end else if (wr) begin
      if (dec.dir)   dir_q   <= wd;
      if (dec.sense) sense_q <= wd;
      if (dec.both)  both_q  <= wd;
      if (dec.pol)   pol_q   <= wd;
      if (dec.msk)   mask_q  <= wd;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         data_q[i] <= 1'b0;
      else if (!dir_q[i])                  data_q[i] <= pin_s[i];
      else if (wr && dec.win && amask[i])  data_q[i] <= wd[i];
    end
  end

  assign clr = (wr && dec.clr) ? wd : '0;

  gpio_irq_unit #(.W(NPINS)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(pin_s), .in_en_i(~dir_q),
    .sense_i(sense_q), .both_i(both_q), .pol_i(pol_q), .mask_i(mask_q),
    .clr_i(clr), .status_o(status), .irq_o(irq_o)
  );

  always_comb begin
    rdata_d = '0;
    if (dec.win)   rdata_d[NPINS-1:0] = data_q & amask;
    if (dec.dir)   rdata_d[NPINS-1:0] = dir_q;
    if (dec.sense) rdata_d[NPINS-1:0] = sense_q;
    if (dec.both)  rdata_d[NPINS-1:0] = both_q;
    if (dec.pol)   rdata_d[NPINS-1:0] = pol_q;
    if (dec.msk)   rdata_d[NPINS-1:0] = mask_q;
    if (dec.raw)   rdata_d[NPINS-1:0] = status;
    if (dec.mis)   rdata_d[NPINS-1:0] = status & mask_q;
    if (dec.id)    rdata_d[7:0]       = id_byte(id_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= rd & dec.unmapped;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
  assign pin_o   = (data_q & dir_q) | ~dir_q;

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && dec.win) |=> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0)); // R3
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rd)); // R13
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0)); // R13
  AST_INPUT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == '0) |-> (pin_o == '1)); // R4
endmodule

// File: tb/gpio_mask_irq_tb_top.sv
module gpio_mask_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  int          cyc = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  gpio_mask_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .pin_i(pin_in),
    .pin_o(pin_out), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata; e = err;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic e;
    rd(a, d, e);
    chk(tag, d, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000 && !done) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d; logic e;
    logic [7:0] idb [12];
    idb = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10, 8'h04, 8'h00,
            8'h0D, 8'hF0, 8'h05, 8'hB1};
    wt(3); rst_n = 1'b1; wt(2);

    // R1 reset state
    chk("R1 pin_o", pin_out, 32'hFF);
    chk("R1 irq", irq, 0);
    rchk("R1 data", 12'h3FC, 0);
    rchk("R1 dir", 12'h400, 0);
    rchk("R1 sense", 12'h404, 0);
    rchk("R1 both", 12'h408, 0);
    rchk("R1 pol", 12'h40C, 0);
    rchk("R1 mask", 12'h410, 0);
    rchk("R1 raw", 12'h414, 0);

    // R6 register storage, upper bits dropped
    wr(12'h404, 32'hFFFF_FF3C); rchk("R6 sense", 12'h404, 32'h3C);
    wr(12'h408, 32'h1234_56A1); rchk("R6 both", 12'h408, 32'hA1);
    wr(12'h40C, 32'hFFFF_FF7E); rchk("R6 pol", 12'h40C, 32'h7E);
    wr(12'h410, 32'h0000_00C3); rchk("R6 mask", 12'h410, 32'hC3);
    wr(12'h400, 32'hABCD_EF96); rchk("R6 dir", 12'h400, 32'h96);
    wr(12'h404, 0); wr(12'h408, 0); wr(12'h40C, 0); wr(12'h410, 0);

    // R2 masked read sweep
    wr(12'h400, 32'hFF);
    foreach (idb[k]) begin end
    for (int v = 0; v < 2; v++) begin
      logic [7:0] pat;
      pat = (v == 0) ? 8'h5A : 8'hC3;
      wr(12'h3FC, {24'h0, pat});
      for (int m = 0; m < 256; m++)
        rchk("R2 masked read", 12'(m << 2), {24'h0, pat & 8'(m)});
    end

    // R3/R4 masked write sweep with mixed direction
    wr(12'h400, 32'hA5);
    pin_in = 8'h00; wt(4);
    for (int m = 0; m < 256; m++) begin
      wr(12'h3FC, 0);
      wr(12'(m << 2), 32'hFF);
      rchk("R3 masked write", 12'h3FC, {24'h0, 8'(m) & 8'hA5});
      chk("R4 pin_o", pin_out, {24'h0, (8'(m) & 8'hA5) | 8'h5A});
    end

    // R5 input follow vs output hold
    wr(12'h400, 32'h0F);
    wr(12'h3FC, 32'h0A);
    pin_in = 8'hF5; wt(4);
    rchk("R5 inputs follow", 12'h3FC, 32'hFA);
    chk("R5 pin_o", pin_out, 32'hFA);
    pin_in = 8'h00; wt(4);
    rchk("R5 inputs follow low", 12'h3FC, 32'h0A);

    // interrupt setup: all inputs, rising, mask off
    wr(12'h400, 0); wt(4);
    wr(12'h404, 0); wr(12'h408, 0); wr(12'h40C, 32'hFF); wr(12'h410, 0);
    wr(12'h41C, 32'hFF); wt(2);
    rchk("R10 raw cleared", 12'h414, 0);
    chk("R11 irq off", irq, 0);

    pin_in = 8'h0F; wt(5);
    rchk("R7 rising edge", 12'h414, 32'h0F);
    rchk("R10 masked zero", 12'h418, 0);
    chk("R11 irq masked", irq, 0);
    wr(12'h410, 32'h03); wt(1);
    rchk("R10 masked", 12'h418, 32'h03);
    chk("R11 irq on", irq, 1);

    wr(12'h41C, 32'h0F); pin_in = 8'h00; wt(5);
    rchk("R7 falling ignored", 12'h414, 0);
    chk("R11 irq after clear", irq, 0);

    wr(12'h40C, 0); wt(2);
    pin_in = 8'hF0; wt(5);
    rchk("R7 rising ignored", 12'h414, 0);
    pin_in = 8'h00; wt(5);
    rchk("R7 falling edge", 12'h414, 32'hF0);

    wr(12'h41C, 32'hFF); wr(12'h408, 32'hFF); wt(2);
    pin_in = 8'h55; wt(5);
    rchk("R8 both rise", 12'h414, 32'h55);
    wr(12'h41C, 32'hFF); wt(2);
    rchk("R8 cleared", 12'h414, 0);
    pin_in = 8'h00; wt(5);
    rchk("R8 both fall", 12'h414, 32'h55);
    wr(12'h41C, 32'hFF); wr(12'h408, 0); wt(2);

    // R9 level sensing on pin 7
    wr(12'h404, 32'h80); wt(3);
    rchk("R9 level low set", 12'h414, 32'h80);
    wr(12'h41C, 32'h80); wt(2);
    rchk("R9 reasserts after clear", 12'h414, 32'h80);
    wr(12'h40C, 32'h80); wr(12'h41C, 32'hFF); wt(2);
    rchk("R9 no match stays clear", 12'h414, 0);
    pin_in = 8'h80; wt(5);
    rchk("R9 level high set", 12'h414, 32'h80);
    chk("R11 irq unmasked pin", irq, 0);
    wr(12'h410, 32'h80); wt(1);
    chk("R11 irq level", irq, 1);
    rchk("R10 masked level", 12'h418, 32'h80);

    // R10 status offsets are read-only
    pin_in = 8'h00; wr(12'h404, 0); wt(4);
    wr(12'h414, 0); wr(12'h418, 0); wt(1);
    rchk("R10 raw write ignored", 12'h414, 32'h80);
    wr(12'h414, 32'hFF); wt(1);
    rchk("R10 raw write no set", 12'h414, 32'h80);

    // R12 identification
    for (int k = 0; k < 12; k++) begin
      rd(12'hFD0 + 12'(k * 4), d, e);
      chk("R12 id byte", d, {24'h0, idb[k]});
      chk("R12 id no error", e, 0);
    end

    // R13 unmapped reads/writes
    wr(12'h40C, 32'h3C);
    rd(12'h41C, d, e); chk("R13 clr read data", d, 0); chk("R13 clr read err", e, 1);
    rd(12'h500, d, e); chk("R13 unmapped data", d, 0); chk("R13 unmapped err", e, 1);
    rd(12'h800, d, e); chk("R13 unmapped2 err", e, 1);
    @(negedge clk); chk("R13 err one cycle", err, 0);
    rd(12'h40C, d, e); chk("R13 mapped no err", e, 0);
    wr(12'h500, 32'hFF); wr(12'hFC0, 32'hFF); wr(12'h420, 32'hFF);
    rchk("R13 write ignored pol", 12'h40C, 32'h3C);
    rchk("R13 write ignored dir", 12'h400, 0);
    rchk("R13 write ignored raw", 12'h414, 32'h80);
    chk("R13 pin_o unchanged", pin_out, 32'hFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule